// File: doc/BRIEF.md
# Binary Digital-Sequence Point Generator

This block emits successive points of a multi-dimensional quasi-random sequence over GF(2). An internal point index starts at zero. It steps by one each time a request strobe is accepted. For every dimension, the index bits are multiplied by a loadable binary generator matrix, with AND as the field product and XOR as the field sum. The resulting bit vector is presented as an unsigned fixed-point fraction in [0,1).

Software, or a sequencer, first fills the per-dimension matrices through a small row-write port while the generator is stopped. It then raises the run input and pulses the request strobe once per wanted point. Dropping run clears the index, which rewinds the sequence. The matrices are kept when run drops. Loading the identity matrix into a dimension makes that coordinate the base-2 radical inverse of the index.

Top module: `dseq_point_gen`

## Requirements
- R1: After reset, pt_valid_o and pt_wrap_o are 0, every fraction output is 0, and every matrix row is 0.
- R2: Row j of a dimension's matrix (j = 0 .. FRAC_W-1) produces fraction bit FRAC_W-1-j, which has weight 2^-(j+1). That bit is the XOR over i of (row j bit i AND index bit i). Index bit 0 is the least significant digit.
- R3: With the identity matrix loaded (row j = 1 << j), the coordinate equals the bit-reversed index, that is, the base-2 radical inverse.
- R4: While run_i is 0 the index is held at 0, so the first point after run_i rises is all zeros in every dimension.
- R5: Each accepted request advances the index by one. The point for the all-ones index is flagged with pt_wrap_o = 1 for its single valid cycle, and the next point uses index 0 again.
- R6: pt_valid_o is 1 exactly in the cycle after a clock edge where run_i and next_i are both 1. A request while run_i is 0 produces no point.
- R7: A row write (ld_we_i, ld_dim_i, ld_row_i, ld_data_i) takes effect only while run_i is 0. A write while run_i is 1 is ignored.
- R8: Between points the fraction outputs hold the last emitted value.
- R9: Each dimension uses only its own matrix. Writing one dimension's rows never changes another dimension's coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = generating; 0 = stopped, index cleared, loads allowed |
| next_i | input | 1 | Request strobe for one point |
| ld_we_i | input | 1 | Matrix row write enable |
| ld_dim_i | input | DIM_W (1) | Dimension selected for the write |
| ld_row_i | input | ROW_W (4) | Row selected for the write |
| ld_data_i | input | IDX_W (16) | Row contents, bit i multiplies index bit i |
| pt_valid_o | output | 1 | Point present this cycle |
| pt_wrap_o | output | 1 | Point was the last before the index wraps |
| pt_frac_o | output | DIMS*FRAC_W (32) | Fractions, dimension d at bits [d*FRAC_W +: FRAC_W] |

## Verification
The bench walks the full 2^16 index range once. A counter that carried wrongly, or a flag raised one point early or late, would misplace pt_wrap_o or fail to restart at a zero point. Row writes issued during generation catch a design that lets a write through and corrupts the sequence in flight. An asymmetric matrix in the second dimension catches an exchange of row and column, or a mirrored bit weight, which the identity case alone would hide. Requests issued while stopped, and idle gaps between requests, expose a stray valid pulse or fraction outputs that do not hold their value.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  localparam int MAX_W = 64;

  // GF(2) inner product: AND is the field product, XOR-reduce is the sum.
  function automatic logic gf2_dot(input logic [MAX_W-1:0] row,
                                   input logic [MAX_W-1:0] digits);
    return ^(row & digits);
  endfunction

  // Matrix row j drives fraction bit (width-1-j): row 0 is the 1/2 weight.
  function automatic int row_to_bit(input int row, input int width);
    return width - 1 - row;
  endfunction

endpackage

// File: rtl/dseq_matrix_store.sv
module dseq_matrix_store #(
  parameter int DIMS   = 2,
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 16,
  localparam int DIM_W = (DIMS > 1) ? $clog2(DIMS) : 1,
  localparam int ROW_W = (FRAC_W > 1) ? $clog2(FRAC_W) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [DIM_W-1:0]              wr_dim,
  input  logic [ROW_W-1:0]              wr_row,
  input  logic [IDX_W-1:0]              wr_data,
  output logic [DIMS*FRAC_W*IDX_W-1:0]  mat_flat
);

  for (genvar d = 0; d < DIMS; d++) begin : g_dim
    for (genvar r = 0; r < FRAC_W; r++) begin : g_row
      logic [IDX_W-1:0] row_q;
      logic             hit;
      assign hit = wr_en && (int'(wr_dim) == d) && (int'(wr_row) == r);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row_q <= '0;
        else if (hit) row_q <= wr_data;
      end
      assign mat_flat[(d*FRAC_W + r)*IDX_W +: IDX_W] = row_q;
    end
  end

endmodule

// File: rtl/dseq_index_ctr.sv
module dseq_index_ctr #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= idx + 1'b1;
  end

  assign at_last = &idx;

endmodule

// File: rtl/dseq_coord_unit.sv
module dseq_coord_unit
  import dseq_pkg::*;
#(
  parameter int DIMS   = 2,
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic [DIMS*FRAC_W*IDX_W-1:0] mat_flat,
  input  logic [IDX_W-1:0]             idx,
  output logic [DIMS*FRAC_W-1:0]       coord
);

  for (genvar d = 0; d < DIMS; d++) begin : g_dim
    for (genvar r = 0; r < FRAC_W; r++) begin : g_row
      localparam int BITPOS = row_to_bit(r, FRAC_W);
      logic [IDX_W-1:0] row_w;
      assign row_w = mat_flat[(d*FRAC_W + r)*IDX_W +: IDX_W];
      assign coord[d*FRAC_W + BITPOS] = gf2_dot(MAX_W'(row_w), MAX_W'(idx));
    end
  end

endmodule

// File: rtl/dseq_point_gen.sv
module dseq_point_gen #(
  parameter int DIMS   = 2,
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 16,
  localparam int DIM_W = (DIMS > 1) ? $clog2(DIMS) : 1,
  localparam int ROW_W = (FRAC_W > 1) ? $clog2(FRAC_W) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic                   next_i,
  input  logic                   ld_we_i,
  input  logic [DIM_W-1:0]       ld_dim_i,
  input  logic [ROW_W-1:0]       ld_row_i,
  input  logic [IDX_W-1:0]       ld_data_i,
  output logic                   pt_valid_o,
  output logic                   pt_wrap_o,
  output logic [DIMS*FRAC_W-1:0] pt_frac_o
);

  // Named internal events, visible to the bound checker.
  logic                          adv_evt;
  logic                          ld_accept;
  logic                          at_last;
  logic [IDX_W-1:0]              idx_w;
  logic [DIMS*FRAC_W*IDX_W-1:0]  mat_flat;
  logic [DIMS*FRAC_W-1:0]        coord_w;

  assign adv_evt   = run_i && next_i;
  assign ld_accept = ld_we_i && !run_i;

  dseq_matrix_store #(.DIMS(DIMS), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_accept),
    .wr_dim   (ld_dim_i),
    .wr_row   (ld_row_i),
    .wr_data  (ld_data_i),
    .mat_flat (mat_flat)
  );

  dseq_index_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!run_i),
    .adv     (adv_evt),
    .idx     (idx_w),
    .at_last (at_last)
  );

  dseq_coord_unit #(.DIMS(DIMS), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_coord (
    .mat_flat (mat_flat),
    .idx      (idx_w),
    .coord    (coord_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_valid_o <= 1'b0;
      pt_wrap_o  <= 1'b0;
      pt_frac_o  <= '0;
    end else begin
      pt_valid_o <= adv_evt;
      pt_wrap_o  <= adv_evt && at_last;
      if (adv_evt) pt_frac_o <= coord_w;
    end
  end

endmodule

// File: rtl/dseq_point_gen_sva.sv
module dseq_point_gen_sva #(
  parameter int DIMS   = 2,
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run_i,
  input logic                         next_i,
  input logic                         pt_valid_o,
  input logic                         pt_wrap_o,
  input logic [DIMS*FRAC_W-1:0]       pt_frac_o,
  input logic [IDX_W-1:0]             idx,
  input logic [DIMS*FRAC_W*IDX_W-1:0] mat_flat
);

  assert_valid_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid_o |-> $past(run_i && next_i));

  assert_no_point_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pt_valid_o);

  assert_index_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (idx == '0));

  assert_wrap_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pt_wrap_o |-> (pt_valid_o && ($past(idx) == {IDX_W{1'b1}})));

  assert_index_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pt_wrap_o |-> (idx == '0));

  assert_matrix_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> $stable(mat_flat));

  assert_frac_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pt_valid_o |-> $stable(pt_frac_o));

endmodule

bind dseq_point_gen dseq_point_gen_sva #(.DIMS(DIMS), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_i      (run_i),
  .next_i     (next_i),
  .pt_valid_o (pt_valid_o),
  .pt_wrap_o  (pt_wrap_o),
  .pt_frac_o  (pt_frac_o),
  .idx        (idx_w),
  .mat_flat   (mat_flat)
);

// File: tb/sim_dseq_point_gen.sv
`timescale 1ns/1ps
module sim_dseq_point_gen;

  localparam int DIMS = 2, M = 16, B = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_i = 1'b0, next_i = 1'b0, ld_we_i = 1'b0;
  logic [0:0]   ld_dim_i = '0;
  logic [3:0]   ld_row_i = '0;
  logic [M-1:0] ld_data_i = '0;
  logic pt_valid_o, pt_wrap_o;
  logic [DIMS*B-1:0] pt_frac_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dseq_point_gen u0 (.*);

  // Behavioural reference model.
  int mm [DIMS][B];
  int m_idx = 0;
  bit e_valid = 0, e_wrap = 0;
  int e_frac [DIMS];

  function automatic int ref_coord(int d, int n);
    int res = 0;
    for (int i = 0; i < M; i++)
      if ((n >> i) & 1)
        for (int j = 0; j < B; j++)
          if ((mm[d][j] >> i) & 1) res = res ^ (1 << (B - 1 - j));
    return res;
  endfunction

  function automatic int bitrev(int n);
    int res = 0;
    for (int i = 0; i < M; i++) if ((n >> i) & 1) res += 1 << (B - 1 - i);
    return res;
  endfunction

  initial begin
    for (int d = 0; d < DIMS; d++) begin
      e_frac[d] = 0;
      for (int j = 0; j < B; j++) mm[d][j] = 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (ld_we_i && !run_i) mm[ld_dim_i][ld_row_i] = ld_data_i;
      if (run_i && next_i) begin
        for (int d = 0; d < DIMS; d++) e_frac[d] = ref_coord(d, m_idx);
        e_valid = 1;
        e_wrap  = (m_idx == (1 << M) - 1);
        m_idx   = (m_idx + 1) % (1 << M);
      end else begin
        e_valid = 0;
        e_wrap  = 0;
      end
      if (!run_i) m_idx = 0;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(pt_valid_o == e_valid, "R6 valid", int'(pt_valid_o), int'(e_valid));
      chk(pt_wrap_o == e_wrap, "R5 wrap", int'(pt_wrap_o), int'(e_wrap));
      for (int d = 0; d < DIMS; d++)
        chk(int'(pt_frac_o[d*B +: B]) == e_frac[d], "R2/R8/R9 fraction",
            int'(pt_frac_o[d*B +: B]), e_frac[d]);
    end
  end

  task automatic load_row(int d, int r, int v);
    @(negedge clk);
    ld_we_i = 1; ld_dim_i = 1'(d); ld_row_i = 4'(r); ld_data_i = M'(v);
    @(negedge clk);
    ld_we_i = 0;
  endtask

  task automatic do_next();
    @(negedge clk); next_i = 1;
    @(negedge clk); next_i = 0;
  endtask

  function automatic int frac(int d);
    return int'(pt_frac_o[d*B +: B]);
  endfunction

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pt_valid_o == 0 && pt_wrap_o == 0, "R1 flags", int'({pt_valid_o, pt_wrap_o}), 0);
    chk(pt_frac_o == '0, "R1 fraction", int'(pt_frac_o), 0);
    rst_n = 1;
    // R1: matrices start at zero, so a nonzero index still gives zero
    @(negedge clk); run_i = 1;
    do_next(); do_next();
    chk(pt_frac_o == '0, "R1 matrix cleared", int'(pt_frac_o), 0);
    @(negedge clk); run_i = 0;

    // R7: loads while stopped. Dim0 identity, dim1 asymmetric.
    for (int j = 0; j < B; j++) begin
      load_row(0, j, 1 << j);
      load_row(1, j, ((j * 16'h1357) ^ 16'h9e37 ^ (1 << (15 - j))) & 16'hffff);
    end
    @(negedge clk); run_i = 1;
    do_next();
    chk(pt_valid_o && frac(0) == 0 && frac(1) == 0, "R4 first point zero",
        int'(pt_frac_o), 0);
    for (int n = 1; n < 40; n++) begin
      do_next();
      chk(frac(0) == bitrev(n), "R3 radical inverse", frac(0), bitrev(n));
      if (n % 5 == 0) repeat (3) @(negedge clk);  // idle gaps for R8
    end

    // R6: requests while stopped produce nothing
    @(negedge clk); run_i = 0;
    do_next();
    chk(pt_valid_o == 0, "R6 stopped request", int'(pt_valid_o), 0);

    // R7: write during run is ignored
    @(negedge clk); run_i = 1;
    load_row(0, 0, 16'hffff);
    do_next(); do_next();
    chk(frac(0) == bitrev(1), "R7 load during run ignored", frac(0), bitrev(1));

    // R9: rewrite dim1 only while stopped; dim0 unchanged
    @(negedge clk); run_i = 0;
    for (int j = 0; j < B; j++) load_row(1, j, (16'ha5c3 >> (j % 7)) ^ (j << 9));
    @(negedge clk); run_i = 1;
    for (int n = 0; n < 20; n++) begin
      do_next();
      chk(frac(0) == bitrev(n), "R9 dim0 untouched", frac(0), bitrev(n));
      chk(frac(1) == ref_coord(1, n), "R2 dim1 product", frac(1), ref_coord(1, n));
    end

    // R5: full index sweep and wrap
    @(negedge clk); run_i = 0;
    @(negedge clk); run_i = 1; next_i = 1;
    for (int k = 0; k < (1 << M); k++) begin
      @(negedge clk);
      if (k == (1 << M) - 2)
        chk(pt_wrap_o == 0, "R5 no early wrap", int'(pt_wrap_o), 0);
      if (k == (1 << M) - 1) begin
        chk(pt_wrap_o == 1 && pt_valid_o == 1, "R5 wrap flag", int'(pt_wrap_o), 1);
        chk(frac(0) == 16'hffff, "R5 last point", frac(0), 16'hffff);
        next_i = 0;
      end
    end
    do_next();
    chk(pt_wrap_o == 0 && frac(0) == 0, "R5 restart at zero", frac(0), 0);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule